// File: doc/BRIEF.md
# Masked Control Register File with Alias Views

This block holds a handful of control and status registers selected by a 12-bit index. One access port carries one operation per cycle: read, write, bit-set or bit-clear. Every physical register has three fixed properties set at elaboration: the bits a read may expose, the bits an update may change, and the value the register takes on reset. Read data is combinational from the current contents. An update lands on the next rising clock edge.

Some indices are alias views rather than storage. An alias points at one physical register and adds a second read mask and a second write mask on top of that register's own masks. An alias whose write mask is zero is a read-only view, and every update through it is dropped. An index that matches neither a register nor an alias is flagged as illegal in the same cycle, reads as zero and changes nothing.

The default map has four registers: machine status at 0x300, scratch at 0x340, exception PC at 0x341 and trap cause at 0x342. It has two aliases: a supervisor status view at 0x100 onto the machine status register, and a read-only scratch view at 0x7C0.

Top module: `csrf_file`

## Requirements
- R1: While reset is low, and after it is released, each physical register holds its reset value: 0x00000A00 for 0x300, zero for 0x340 and 0x341, and 0x00000100 for 0x342.
- R2: A read (operation code 0) returns the register's raw contents ANDed with its read mask. The read masks are 0x00000FFF (0x300), all ones (0x340, 0x341) and 0x8000001F (0x342). The read data is zero whenever no request is valid.
- R3: A write (operation code 1) stores (operand & wmask) | (old & ~wmask). The write masks are 0x0000F0FF (0x300), all ones (0x340), 0xFFFFFFFC (0x341) and 0x800000FF (0x342).
- R4: A bit-set (operation code 2) performs a masked write of (raw contents | operand).
- R5: A bit-clear (operation code 3) performs a masked write of (raw contents & ~operand).
- R6: A read through an alias returns the target's masked read value ANDed with the alias read mask. For 0x100 that mask is 0x000008F3; for 0x7C0 it is 0x0000FFFF.
- R7: An update through an alias with a nonzero write mask first forms (target raw & ~awmask) | (argument & awmask), where the argument is the operand, raw|operand or raw&~operand for operation codes 1, 2 and 3. It then applies that value to the target as a normal masked write. For 0x100 the alias write mask is 0x00001033.
- R8: Writes, sets and clears through an alias with a zero write mask (0x7C0) leave the target unchanged.
- R9: A valid request to an unmapped index raises `illegal` in that same cycle, returns zero read data and changes no register.
- R10: An update is visible from the next clock edge. During the update cycle the read data shows the old contents. Reads and idle cycles change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation: 0 read, 1 write, 2 set bits, 3 clear bits |
| req_idx | input | 12 | Register or alias index |
| req_wdata | input | XLEN (32) | Operand for write, set and clear |
| rd_data | output | XLEN (32) | Masked read value of the addressed index |
| illegal | output | 1 | Valid request to an unmapped index |

## Verification
The checker watches four things on every cycle. Register contents stay frozen after an illegal access, a read or an idle cycle, and after any request to a read-only alias. Read data is zero whenever the flag is raised or no request is valid. The exact arithmetic of the merges needs the bench's scenarios with hand-derived expected values: masked writes keeping bits they may not touch, set and clear working from the raw value, and the two mask layers of an alias write combining with the target's mask. Reset values and the one-cycle visibility of updates are also shown only by those scenarios.

// File: rtl/csrf_pkg.sv
package csrf_pkg;

  localparam int IDX_W = 12;

  typedef enum logic [1:0] {
    CSR_RD  = 2'd0,
    CSR_WR  = 2'd1,
    CSR_SET = 2'd2,
    CSR_CLR = 2'd3
  } csr_op_e;

endpackage

// File: rtl/csrf_decode.sv
module csrf_decode
  import csrf_pkg::*;
#(
  parameter int NPHYS  = 4,
  parameter int NALIAS = 2,
  parameter logic [IDX_W-1:0] P_IDX [NPHYS]  = '{12'h300, 12'h340, 12'h341, 12'h342},
  parameter logic [IDX_W-1:0] A_IDX [NALIAS] = '{12'h100, 12'h7C0}
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [NPHYS-1:0]  phys_sel,
  output logic [NALIAS-1:0] alias_sel,
  output logic              hit
);

  // One comparator per mapped index; each index is expected to be unique.
  for (genvar p = 0; p < NPHYS; p++) begin : g_phys
    assign phys_sel[p] = (idx == P_IDX[p]);
  end

  for (genvar a = 0; a < NALIAS; a++) begin : g_alias
    assign alias_sel[a] = (idx == A_IDX[a]);
  end

  assign hit = (|phys_sel) | (|alias_sel);

endmodule

// File: rtl/csrf_merge.sv
module csrf_merge
  import csrf_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  csr_op_e         op,
  input  logic [XLEN-1:0] operand,
  input  logic [XLEN-1:0] raw,
  input  logic [XLEN-1:0] rmask,
  input  logic [XLEN-1:0] wmask,
  input  logic [XLEN-1:0] armask,
  input  logic [XLEN-1:0] awmask,
  output logic [XLEN-1:0] rd_val,
  output logic [XLEN-1:0] nxt_val,
  output logic            touch
);

  logic [XLEN-1:0] arg;
  logic [XLEN-1:0] eff;

  // Set and clear are formed from the raw contents, not the read view.
  always_comb begin
    unique case (op)
      CSR_SET: arg = raw | operand;
      CSR_CLR: arg = raw & ~operand;
      default: arg = operand;
    endcase
  end

  // Alias layer then target layer collapse into a single AND of the masks.
  assign eff     = wmask & awmask;
  assign nxt_val = (arg & eff) | (raw & ~eff);
  assign rd_val  = raw & rmask & armask;
  assign touch   = (op != CSR_RD) && (|eff);

endmodule

// File: rtl/csrf_cell.sv
module csrf_cell #(
  parameter int              XLEN = 32,
  parameter logic [XLEN-1:0] RST  = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [XLEN-1:0] d,
  output logic [XLEN-1:0] q
);

  logic [XLEN-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) begin
      q_nxt = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST;
    end else begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/csrf_file.sv
module csrf_file
  import csrf_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int NPHYS  = 4,
  parameter int NALIAS = 2,
  parameter logic [IDX_W-1:0] P_IDX   [NPHYS] = '{12'h300, 12'h340, 12'h341, 12'h342},
  parameter logic [XLEN-1:0]  P_RST   [NPHYS] = '{32'h0000_0A00, 32'h0, 32'h0, 32'h0000_0100},
  parameter logic [XLEN-1:0]  P_RMASK [NPHYS] = '{32'h0000_0FFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h8000_001F},
  parameter logic [XLEN-1:0]  P_WMASK [NPHYS] = '{32'h0000_F0FF, 32'hFFFF_FFFF, 32'hFFFF_FFFC, 32'h8000_00FF},
  parameter logic [IDX_W-1:0] A_IDX   [NALIAS] = '{12'h100, 12'h7C0},
  parameter int               A_TGT   [NALIAS] = '{0, 1},
  parameter logic [XLEN-1:0]  A_RMASK [NALIAS] = '{32'h0000_08F3, 32'h0000_FFFF},
  parameter logic [XLEN-1:0]  A_WMASK [NALIAS] = '{32'h0000_1033, 32'h0}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [XLEN-1:0]  req_wdata,
  output logic [XLEN-1:0]  rd_data,
  output logic             illegal
);

  logic [NPHYS-1:0]      phys_sel;
  logic [NALIAS-1:0]     alias_sel;
  logic                  hit;
  logic [NPHYS-1:0]      tgt_sel;
  logic [XLEN-1:0]       state_q [NPHYS];
  logic [NPHYS*XLEN-1:0] state_flat;
  logic [XLEN-1:0]       raw, rmask, wmask, armask, awmask;
  logic [XLEN-1:0]       arm_acc, awm_acc;
  logic [XLEN-1:0]       rd_val, nxt_val;
  logic                  touch;
  logic                  wr_go;

  csrf_decode #(
    .NPHYS (NPHYS),
    .NALIAS(NALIAS),
    .P_IDX (P_IDX),
    .A_IDX (A_IDX)
  ) u_dec (
    .idx      (req_idx),
    .phys_sel (phys_sel),
    .alias_sel(alias_sel),
    .hit      (hit)
  );

  // Resolve the addressed index to one physical target and its mask set.
  always_comb begin
    tgt_sel = phys_sel;
    arm_acc = '0;
    awm_acc = '0;
    for (int a = 0; a < NALIAS; a++) begin
      if (alias_sel[a]) begin
        tgt_sel[A_TGT[a]] = 1'b1;
        arm_acc = arm_acc | A_RMASK[a];
        awm_acc = awm_acc | A_WMASK[a];
      end
    end
    armask = (|alias_sel) ? arm_acc : '1;
    awmask = (|alias_sel) ? awm_acc : '1;
    raw   = '0;
    rmask = '0;
    wmask = '0;
    for (int p = 0; p < NPHYS; p++) begin
      if (tgt_sel[p]) begin
        raw   = raw   | state_q[p];
        rmask = rmask | P_RMASK[p];
        wmask = wmask | P_WMASK[p];
      end
    end
  end

  csrf_merge #(.XLEN(XLEN)) u_merge (
    .op     (csr_op_e'(req_op)),
    .operand(req_wdata),
    .raw    (raw),
    .rmask  (rmask),
    .wmask  (wmask),
    .armask (armask),
    .awmask (awmask),
    .rd_val (rd_val),
    .nxt_val(nxt_val),
    .touch  (touch)
  );

  assign wr_go   = req_valid && hit && touch;
  assign rd_data = (req_valid && hit) ? rd_val : '0;
  assign illegal = req_valid && !hit;

  for (genvar g = 0; g < NPHYS; g++) begin : g_reg
    csrf_cell #(
      .XLEN(XLEN),
      .RST (P_RST[g])
    ) u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (wr_go && tgt_sel[g]),
      .d    (nxt_val),
      .q    (state_q[g])
    );
    assign state_flat[g*XLEN +: XLEN] = state_q[g];
  end

endmodule

// File: rtl/csrf_file_chk.sv
module csrf_file_chk
  import csrf_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int NPHYS  = 4,
  parameter int NALIAS = 2,
  parameter logic [IDX_W-1:0] A_IDX   [NALIAS] = '{12'h100, 12'h7C0},
  parameter logic [XLEN-1:0]  A_WMASK [NALIAS] = '{32'h0000_1033, 32'h0}
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic [1:0]            req_op,
  input logic [IDX_W-1:0]      req_idx,
  input logic [XLEN-1:0]       rd_data,
  input logic                  illegal,
  input logic [NPHYS*XLEN-1:0] state_flat
);

  p_illegal_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (rd_data == '0))
    else $error("illegal access returned nonzero data");

  p_illegal_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> $stable(state_flat))
    else $error("illegal access changed a register");

  p_idle_read_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || (req_op == 2'(CSR_RD))) |=> $stable(state_flat))
    else $error("read or idle cycle changed a register");

  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> ((rd_data == '0) && !illegal))
    else $error("idle cycle drove data or flag");

  // R8: read-only alias views never alter any register.
  for (genvar a = 0; a < NALIAS; a++) begin : g_ro
    if (A_WMASK[a] == '0) begin : g_on
      p_ro_alias_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_idx == A_IDX[a])) |=> $stable(state_flat))
        else $error("read-only alias changed a register");
    end
  end

endmodule

bind csrf_file csrf_file_chk #(
  .XLEN   (XLEN),
  .NPHYS  (NPHYS),
  .NALIAS (NALIAS),
  .A_IDX  (A_IDX),
  .A_WMASK(A_WMASK)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_op    (req_op),
  .req_idx   (req_idx),
  .rd_data   (rd_data),
  .illegal   (illegal),
  .state_flat(state_flat)
);

// File: tb/csrf_file_tb_top.sv
module csrf_file_tb_top;
  import csrf_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [11:0] req_idx = 12'd0;
  logic [31:0] req_wdata = 32'd0;
  logic [31:0] rd_data;
  logic        illegal;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  csrf_file dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_op   (req_op),
    .req_idx  (req_idx),
    .req_wdata(req_wdata),
    .rd_data  (rd_data),
    .illegal  (illegal)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic access(input logic [1:0] op, input logic [11:0] idx, input logic [31:0] wd,
                        output logic [31:0] rd, output logic ill);
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_idx   = idx;
    req_wdata = wd;
    #1;
    rd  = rd_data;
    ill = illegal;
    @(posedge clk);
  endtask

  task automatic go_idle;
    @(negedge clk);
    req_valid = 1'b0;
    req_op    = 2'd0;
    req_idx   = 12'd0;
    req_wdata = 32'd0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] idx, input logic [31:0] exp);
    logic [31:0] rd;
    logic        ill;
    access(CSR_RD, idx, 32'd0, rd, ill);
    chk(tag, rd, exp);
    chk({tag, " flag"}, {31'd0, ill}, 32'd0);
  endtask

  task automatic upd(input string tag, input logic [1:0] op, input logic [11:0] idx,
                     input logic [31:0] wd);
    logic [31:0] rd;
    logic        ill;
    access(op, idx, wd, rd, ill);
    chk({tag, " flag"}, {31'd0, ill}, 32'd0);
  endtask

  task automatic t_reset;
    rd_chk("R1 status reset", 12'h300, 32'h0000_0A00);
    rd_chk("R1 scratch reset", 12'h340, 32'h0);
    rd_chk("R1 epc reset", 12'h341, 32'h0);
    rd_chk("R1 cause reset hidden by mask", 12'h342, 32'h0);
    rd_chk("R6 alias status reset", 12'h100, 32'h0000_0800);
    rd_chk("R6 alias scratch reset", 12'h7C0, 32'h0);
  endtask

  task automatic t_write;
    logic [31:0] rd;
    logic        ill;
    access(CSR_WR, 12'h340, 32'hDEAD_BEEF, rd, ill);
    chk("R10 old value during write", rd, 32'h0);
    rd_chk("R3 scratch full write", 12'h340, 32'hDEAD_BEEF);
    upd("R3 epc write", CSR_WR, 12'h341, 32'h1234_5677);
    rd_chk("R3 epc low bits kept", 12'h341, 32'h1234_5674);
    upd("R3 status write ones", CSR_WR, 12'h300, 32'hFFFF_FFFF);
    rd_chk("R3 status merged", 12'h300, 32'h0000_0AFF);
    upd("R3 status write zero", CSR_WR, 12'h300, 32'h0);
    rd_chk("R3 status fixed bits kept", 12'h300, 32'h0000_0A00);
  endtask

  task automatic t_rmask;
    upd("R2 cause write ones", CSR_WR, 12'h342, 32'hFFFF_FFFF);
    rd_chk("R2 cause read masked", 12'h342, 32'h8000_001F);
    go_idle;
    #1;
    chk("R2 idle read data", rd_data, 32'h0);
    chk("R2 idle flag", {31'd0, illegal}, 32'h0);
  endtask

  task automatic t_setclr;
    upd("R4 scratch set", CSR_SET, 12'h340, 32'h0000_0011);
    rd_chk("R4 scratch after set", 12'h340, 32'hDEAD_BEFF);
    upd("R5 scratch clear", CSR_CLR, 12'h340, 32'hFF00_0000);
    rd_chk("R5 scratch after clear", 12'h340, 32'h00AD_BEFF);
    upd("R4 status set", CSR_SET, 12'h300, 32'h0000_F00F);
    rd_chk("R4 status after set", 12'h300, 32'h0000_0A0F);
    upd("R5 status clear", CSR_CLR, 12'h300, 32'h0000_0F03);
    rd_chk("R5 status clear keeps fixed bits", 12'h300, 32'h0000_0A0C);
    upd("R4 epc set", CSR_SET, 12'h341, 32'h0000_0003);
    rd_chk("R4 epc set masked", 12'h341, 32'h1234_5674);
  endtask

  task automatic t_alias_rd;
    rd_chk("R6 status direct", 12'h300, 32'h0000_0A0C);
    rd_chk("R6 status via alias", 12'h100, 32'h0000_0800);
  endtask

  task automatic t_alias_wr;
    upd("R7 alias write ones", CSR_WR, 12'h100, 32'hFFFF_FFFF);
    rd_chk("R7 target after alias write", 12'h300, 32'h0000_0A3F);
    rd_chk("R7 alias view after write", 12'h100, 32'h0000_0833);
    upd("R7 alias write zero", CSR_WR, 12'h100, 32'h0);
    rd_chk("R7 alias zero keeps unmasked bits", 12'h300, 32'h0000_0A0C);
    upd("R7 alias set outside mask", CSR_SET, 12'h100, 32'h0000_0080);
    rd_chk("R7 set outside mask ignored", 12'h300, 32'h0000_0A0C);
    upd("R7 alias set inside mask", CSR_SET, 12'h100, 32'h0000_0010);
    rd_chk("R7 set inside mask", 12'h300, 32'h0000_0A1C);
    upd("R7 alias clear", CSR_CLR, 12'h100, 32'h0000_001C);
    rd_chk("R7 clear limited by alias mask", 12'h300, 32'h0000_0A0C);
  endtask

  task automatic t_alias_ro;
    upd("R8 ro alias write", CSR_WR, 12'h7C0, 32'h0000_1111);
    rd_chk("R8 scratch after ro write", 12'h340, 32'h00AD_BEFF);
    upd("R8 ro alias set", CSR_SET, 12'h7C0, 32'hFFFF_FFFF);
    upd("R8 ro alias clear", CSR_CLR, 12'h7C0, 32'hFFFF_FFFF);
    rd_chk("R8 scratch after ro set and clear", 12'h340, 32'h00AD_BEFF);
    rd_chk("R8 ro alias view", 12'h7C0, 32'h0000_BEFF);
  endtask

  task automatic t_illegal;
    logic [31:0] rd;
    logic        ill;
    access(CSR_WR, 12'h345, 32'hFFFF_FFFF, rd, ill);
    chk("R9 write flag", {31'd0, ill}, 32'd1);
    chk("R9 write data zero", rd, 32'h0);
    access(CSR_RD, 12'h000, 32'h0, rd, ill);
    chk("R9 read flag", {31'd0, ill}, 32'd1);
    chk("R9 read data zero", rd, 32'h0);
    access(CSR_SET, 12'h7FF, 32'hFFFF_FFFF, rd, ill);
    chk("R9 set flag", {31'd0, ill}, 32'd1);
    rd_chk("R9 status unchanged", 12'h300, 32'h0000_0A0C);
    rd_chk("R9 scratch unchanged", 12'h340, 32'h00AD_BEFF);
    rd_chk("R9 epc unchanged", 12'h341, 32'h1234_5674);
    rd_chk("R9 cause unchanged", 12'h342, 32'h8000_001F);
    go_idle;
    #1;
    chk("R9 flag drops when idle", {31'd0, illegal}, 32'h0);
  endtask

  task automatic t_rereset;
    @(negedge clk);
    rst_n     = 1'b0;
    req_valid = 1'b1;
    req_op    = CSR_RD;
    req_idx   = 12'h341;
    #1;
    chk("R1 epc during reset", rd_data, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    rd_chk("R1 status after reset", 12'h300, 32'h0000_0A00);
    rd_chk("R1 scratch after reset", 12'h340, 32'h0);
    rd_chk("R1 cause after reset", 12'h342, 32'h0);
    go_idle;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write();
    t_rmask();
    t_setclr();
    t_alias_rd();
    t_alias_wr();
    t_alias_ro();
    t_illegal();
    t_rereset();
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R10 watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule